// File: doc/BRIEF.md
# Raster Sync and Graticule Timebase

This block produces every timing signal a small trace display needs. Its only time reference is the design clock, nominally 4 MHz, so one tick lasts 250 ns. A single free-running 16-bit binary count advances by one on each tick. All outputs are decoded from that count: the horizontal and vertical sync pulses, a dotted vertical graticule, a horizontal graticule line centred on the screen, the 8-bit line index that trace memories compare against, and three read strobes for playing back at full, half and quarter rate.

A scan line lasts 128 ticks (32 µs) and a frame lasts 65,536 ticks, which is about 61 Hz. The horizontal graticule is requested once every 8,192 ticks, eight times per frame. The request is held back by a parameterised delay, `HG_DELAY`, given in ticks, so that one of the eight lines falls at mid-screen. The delayed request is then realigned to the sync pulse, so the graticule line fills exactly one scan line.

Every output is registered and is decoded from the value the count is about to take. The outputs therefore change on the same edge as the count and never glitch. All pins are plain level signals; there is no data stream at the edge of the block.

Top module: `raster_timebase`

## Requirements
- R1: While reset is held, the block holds the count-zero state: hsync_n_o=1, vsync_n_o=1, vgrat_o=1, hgrat_o=0, line_idx_o=0, rd_stb_o=3'b111.
- R2: vgrat_o is high for exactly one tick whenever the low 4 bits of the count are zero. This gives 8 pulses per line, 16 ticks apart.
- R3: hsync_n_o is low for the 8 ticks where count bits [6:3] are all ones (line phase 120..127) and high otherwise. It returns high on the same tick that the first vertical graticule pulse of the next line appears.
- R4: vsync_n_o is low for the 256 ticks where count bits [15:8] are all ones, once every 65,536 ticks.
- R5: line_idx_o equals count bits [15:8]. It steps by one every 256 ticks (two scan lines) and wraps from 255 to 0.
- R6: rd_stb_o[0] is high on every tick. rd_stb_o[1] is high when count bit 0 is 0. rd_stb_o[2] is high when count bits [1:0] are 0.
- R7: The centring delay restarts whenever count bits [12:0] return to zero. A graticule request becomes pending HG_DELAY ticks later.
- R8: A pending request is taken up at the next tick where hsync_n_o falls. hgrat_o then stays high for exactly 128 ticks, up to the following sync fall. With the default HG_DELAY=4096, this places hgrat_o high for count[12:0] in 4216..4343.
- R9: Asserting reset in the middle of a frame restarts all timing from count zero, and the sequence after release is identical to the one after the first reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Tick clock (nominally 4 MHz) |
| rst_i | input | 1 | Synchronous reset, active high |
| hsync_n_o | output | 1 | Line sync, active low |
| vsync_n_o | output | 1 | Frame sync, active low |
| vgrat_o | output | 1 | Vertical graticule dot pulse |
| hgrat_o | output | 1 | Centred horizontal graticule line |
| line_idx_o | output | 8 | Line index for trace comparison |
| rd_stb_o | output | 3 | Playback read strobes: full, half and quarter rate |

## Verification
Every output is due on the same edge that moves the count to the value it decodes. After release from reset, the n-th rising edge therefore presents the decode of count n, and while reset is held the block shows the decode of count zero. The bench keeps its own tick number. It pushes the expected outputs for that tick one nanosecond after each rising edge and compares them on the following falling edge, so every result is sampled in the cycle it is due. The one exception is hgrat_o, which is due on the first sync fall at least one tick after the pending point. The bench derives that tick from HG_DELAY rather than from the design.

// File: rtl/rtb_pkg.sv
package rtb_pkg;
  localparam int CNT_W       = 16;
  localparam int GRAT_BITS   = 4;
  localparam int SYNC_BITS   = 3;
  localparam int LINE_BITS   = 7;
  localparam int LIDX_LSB    = 8;
  localparam int LIDX_W      = CNT_W - LIDX_LSB;
  localparam int HG_BITS     = 13;
  localparam int NUM_RD      = 3;
  localparam int HSYNC_TICKS = 1 << SYNC_BITS;
  localparam int LINE_TICKS  = 1 << LINE_BITS;
  localparam int VSYNC_TICKS = 1 << LIDX_LSB;
  localparam int SYNC_START  = LINE_TICKS - HSYNC_TICKS;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    logic              hs_n;
    logic              vs_n;
    logic              vg;
    logic [LIDX_W-1:0] lidx;
    logic [NUM_RD-1:0] stb;
  } dec_t;
endpackage

// File: rtl/rtb_counter.sv
module rtb_counter
  import rtb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  output cnt_t nxt_o
);
  cnt_t cnt_q;

  assign nxt_o = rst_i ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk_i) begin
    if (rst_i) cnt_q <= '0;
    else       cnt_q <= nxt_o;
  end
endmodule

// File: rtl/rtb_decode.sv
module rtb_decode
  import rtb_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic [LIDX_W-1:0]    hi_i,
  input  logic [LINE_BITS-1:0] lo_i,
  output dec_t                 dec_o
);
  dec_t d_nxt, d_q;
  logic [NUM_RD-1:0] stb_nxt;

  // one strobe per read rate, rate r fires every 2**r ticks
  for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
    if (r == 0) begin : g_full
      assign stb_nxt[r] = 1'b1;
    end else begin : g_div
      assign stb_nxt[r] = (lo_i[r-1:0] == '0);
    end
  end

  always_comb begin
    d_nxt.hs_n = ~(&lo_i[LINE_BITS-1:SYNC_BITS]);
    d_nxt.vs_n = ~(&hi_i);
    d_nxt.vg   = (lo_i[GRAT_BITS-1:0] == '0);
    d_nxt.lidx = hi_i;
    d_nxt.stb  = stb_nxt;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      d_q.hs_n <= 1'b1;
      d_q.vs_n <= 1'b1;
      d_q.vg   <= 1'b1;
      d_q.lidx <= '0;
      d_q.stb  <= '1;
    end else begin
      d_q <= d_nxt;
    end
  end

  assign dec_o = d_q;
endmodule

// File: rtl/rtb_hgrat.sv
module rtb_hgrat
  import rtb_pkg::*;
#(
  parameter int HG_DELAY = 4096
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [HG_BITS-1:0] k_i,
  output logic               hg_o
);
  localparam logic [HG_BITS-1:0] DLY_INIT = HG_BITS'(HG_DELAY);
  localparam logic [LINE_BITS-1:0] SMP_PH = LINE_BITS'(SYNC_START);

  logic [HG_BITS-1:0] dly_q;
  logic pend_q, hg_q;
  logic restart, sample, expire;

  assign restart = (k_i == '0);
  assign sample  = (k_i[LINE_BITS-1:0] == SMP_PH);
  assign expire  = !restart && (dly_q == HG_BITS'(1));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      dly_q <= DLY_INIT;
    end else if (restart) begin
      dly_q <= DLY_INIT;
    end else if (dly_q != '0) begin
      dly_q <= dly_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pend_q <= 1'b0;
      hg_q   <= 1'b0;
    end else begin
      if (expire)      pend_q <= 1'b1;
      else if (sample) pend_q <= 1'b0;
      if (sample)      hg_q   <= pend_q;
    end
  end

  assign hg_o = hg_q;
endmodule

// File: rtl/raster_timebase.sv
module raster_timebase
  import rtb_pkg::*;
#(
  parameter int HG_DELAY = 4096
) (
  input  logic              clk_i,
  input  logic              rst_i,
  output logic              hsync_n_o,
  output logic              vsync_n_o,
  output logic              vgrat_o,
  output logic              hgrat_o,
  output logic [LIDX_W-1:0] line_idx_o,
  output logic [NUM_RD-1:0] rd_stb_o
);
  cnt_t nxt;
  dec_t dec;

  rtb_counter u_cnt (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .nxt_o (nxt)
  );

  rtb_decode u_dec (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .hi_i  (nxt[CNT_W-1:LIDX_LSB]),
    .lo_i  (nxt[LINE_BITS-1:0]),
    .dec_o (dec)
  );

  rtb_hgrat #(.HG_DELAY(HG_DELAY)) u_hg (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .k_i   (nxt[HG_BITS-1:0]),
    .hg_o  (hgrat_o)
  );

  assign hsync_n_o  = dec.hs_n;
  assign vsync_n_o  = dec.vs_n;
  assign vgrat_o    = dec.vg;
  assign line_idx_o = dec.lidx;
  assign rd_stb_o   = dec.stb;
endmodule

// File: rtl/raster_timebase_chk.sv
module raster_timebase_chk
  import rtb_pkg::*;
(
  input logic              clk_i,
  input logic              rst_i,
  input logic              hsync_n_o,
  input logic              vsync_n_o,
  input logic              vgrat_o,
  input logic              hgrat_o,
  input logic [LIDX_W-1:0] line_idx_o,
  input logic [NUM_RD-1:0] rd_stb_o
);
  logic [7:0]  hs_run;
  logic [15:0] vs_run;
  logic [8:0]  hg_run;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      hs_run <= '0;
      vs_run <= '0;
      hg_run <= '0;
    end else begin
      hs_run <= hsync_n_o ? '0 : hs_run + 1'b1;
      vs_run <= vsync_n_o ? '0 : vs_run + 1'b1;
      hg_run <= hgrat_o   ? hg_run + 1'b1 : '0;
    end
  end

  AST_VGRAT_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
    vgrat_o |=> !vgrat_o); // R2
  AST_HSYNC_WIDTH: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(hsync_n_o) |-> (hs_run == 8'(HSYNC_TICKS))); // R3
  AST_SYNC_THEN_DOT: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(hsync_n_o) |-> vgrat_o); // R3
  AST_VSYNC_WIDTH: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(vsync_n_o) |-> (vs_run == 16'(VSYNC_TICKS))); // R4
  AST_VSYNC_LAST_IDX: assert property (@(posedge clk_i) disable iff (rst_i)
    !vsync_n_o |-> (&line_idx_o)); // R4
  AST_LIDX_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(line_idx_o) |-> (line_idx_o == $past(line_idx_o) + 1'b1)); // R5
  AST_STB_NEST: assert property (@(posedge clk_i) disable iff (rst_i)
    rd_stb_o[0] && (rd_stb_o[2] -> rd_stb_o[1])); // R6
  AST_HGRAT_ON_SYNC: assert property (@(posedge clk_i) disable iff (rst_i)
    (hgrat_o != $past(hgrat_o)) |-> $fell(hsync_n_o)); // R8
  AST_HGRAT_ONE_LINE: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(hgrat_o) |-> (hg_run == 9'(LINE_TICKS))); // R8
endmodule

bind raster_timebase raster_timebase_chk u_chk (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .hsync_n_o  (hsync_n_o),
  .vsync_n_o  (vsync_n_o),
  .vgrat_o    (vgrat_o),
  .hgrat_o    (hgrat_o),
  .line_idx_o (line_idx_o),
  .rd_stb_o   (rd_stb_o)
);

// File: tb/tb_raster_timebase.sv
`timescale 1ns/1ps
module tb_raster_timebase;
  localparam int D = 4096;

  typedef struct {
    logic       hs, vs, vg, hg;
    logic [7:0] ln;
    logic [2:0] stb;
    int         tag;
    int         tick;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hs_n, vs_n, vg, hg;
  logic [7:0] ln;
  logic [2:0] stb;

  int checks = 0, failures = 0;
  bit done = 0;
  exp_t q[$];
  logic [15:0] c;

  always #2 clk = ~clk;

  raster_timebase #(.HG_DELAY(D)) dut (
    .clk_i(clk), .rst_i(rst), .hsync_n_o(hs_n), .vsync_n_o(vs_n),
    .vgrat_o(vg), .hgrat_o(hg), .line_idx_o(ln), .rd_stb_o(stb)
  );

  function automatic exp_t model(input logic [15:0] v, input int tag);
    exp_t e;
    int k, s;
    s = D + 1;
    while (s % 128 != 120) s++;
    k = int'(v[12:0]);
    e.hs  = !(v[6:3] == 4'hF);
    e.vs  = !(v[15:8] == 8'hFF);
    e.vg  = (v[3:0] == 4'h0);
    e.ln  = v[15:8];
    e.stb = {v[1:0] == 2'b00, v[0] == 1'b0, 1'b1};
    e.hg  = (k >= s && k < s + 128) || (k + 8192 < s + 128);
    e.tag = tag;
    e.tick = int'(v);
    return e;
  endfunction

  task automatic cmp(input string req, input logic [7:0] got, input logic [7:0] want, input int t);
    checks++;
    if (got !== want) begin
      failures++;
      $display("FAIL %s tick=%0d actual=%0h expected=%0h", req, t, got, want);
    end
  endtask

  // monitor: pops expected items and compares away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      string pre;
      e = q.pop_front();
      pre = (e.tag == 1) ? "R1 " : (e.tag == 2) ? "R9 " : "";
      cmp({pre, "R3 hsync"}, {7'd0, hs_n}, {7'd0, e.hs}, e.tick);
      cmp({pre, "R4 vsync"}, {7'd0, vs_n}, {7'd0, e.vs}, e.tick);
      cmp({pre, "R2 vgrat"}, {7'd0, vg}, {7'd0, e.vg}, e.tick);
      cmp({pre, "R5 line"}, ln, e.ln, e.tick);
      cmp({pre, "R6 strobes"}, {5'd0, stb}, {5'd0, e.stb}, e.tick);
      cmp({pre, "R7 R8 hgrat"}, {7'd0, hg}, {7'd0, e.hg}, e.tick);
    end
  end

  // driver: reset, then one expected item per tick
  task automatic do_reset(input int tag);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    c = '0;
    q.push_back(model(c, tag));
    rst = 1'b0;
  endtask

  task automatic run_ticks(input int n, input int tag_first);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      c = c + 1'b1;
      q.push_back(model(c, (i < 300) ? tag_first : 0));
    end
  endtask

  initial begin
    do_reset(1);
    run_ticks(65536 + 8800, 0);   // full frame plus one more graticule period
    repeat (37) @(posedge clk);   // mid-frame: timing runs on unchecked
    do_reset(2);
    run_ticks(4500, 2);           // R9: replay after reset matches first run
    repeat (3) @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule